// File: doc/BRIEF.md
# Indirect Sideband Register Access Bridge

The bridge is a memory-mapped target that gives a host access to a private, indexed register space through a small window of registers. The host sets a target index, a 32-bit data value, an 8-bit opcode and an 8-bit route identifier, and then writes the go bit. The bridge issues one request on a valid/ready backend port. It waits for the matching response and then finishes the transaction. On finish it stores read data in the data register, records a 2-bit completion code and drops the busy flag.

The window has three 32-bit words. Word 0x0 holds the index and word 0x4 holds the data. Word 0x8 is the control word:

- bit 0 is go/busy.
- bits 2:1 are the completion code, read-only.
- bits 15:8 are the opcode.
- bits 23:16 are the route identifier.
- bits 31:24 are the routing upper byte, and its top nibble must equal a fixed key.

Byte enables let the host change one field of the control word without disturbing the others. A request whose routing key is wrong ends at once with code 3 and does not reach the backend. A request that stalls ends with code 2 after a bounded number of cycles.

Top module: `sideband_bridge`

## Requirements
- R1: After reset, all three words read 0. This includes the routing key nibble, so the key is invalid until it is written.
- R2: Host writes honour byte enables. Enable bit n updates only bits 8n+7:8n of the addressed word. In the control word, the completion code (bits 2:1) is never host-writable, and a write that leaves enable 0 clear cannot start a transaction.
- R3: A write to word 0x8 with enable 0 set and bit 0 = 1, while idle, makes bit 0 read 1 from the next cycle on. It also issues one backend request carrying the index, opcode, route identifier (bits 23:16) and data register.
- R4: While a request is offered and not accepted, the request stays valid and its fields stay unchanged until it is accepted or the timeout ends it.
- R5: For opcode 0x06 or 0x04 (reads), the backend response data is written into the data register. The backend status is written into bits 2:1. Both updates take place in the same cycle that busy clears.
- R6: For any other opcode, including the writes 0x07 and 0x05, the data register is sent to the backend and keeps its value. Only the backend status is recorded.
- R7: Bits 2:1 change only in the cycle where busy falls. While busy is 1 they still show the previous code.
- R8: If bits 31:28 differ from the routing key (0xF) when the request would be issued, busy stays 1 for exactly one cycle, the code becomes 3, and no request is offered.
- R9: A transaction still open TIMEOUT cycles after go ends with code 2. Busy is then 1 for exactly TIMEOUT cycles. If a response arrives in the expiry cycle, the response is used.
- R10: While busy is 1, host writes to the index, data, opcode, route and go fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host write strobe |
| host_addr | input | HAW | Host byte address of the word (0x0, 0x4, 0x8) |
| host_be | input | DW/8 | Host byte enables |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data of the addressed word, combinational |
| bk_req_valid | output | 1 | Backend request offered |
| bk_req_ready | input | 1 | Backend accepts the request |
| bk_req_addr | output | DW | Target index |
| bk_req_op | output | 8 | Opcode |
| bk_req_route | output | 8 | Route identifier |
| bk_req_wdata | output | DW | Write data |
| bk_rsp_valid | input | 1 | Backend response present for one cycle |
| bk_rsp_data | input | DW | Response read data |
| bk_rsp_status | input | 2 | Response status, 0 = success |

## Verification
The bench builds the bridge with TIMEOUT = 16 and keeps the defaults DW = 32, HAW = 4 and routing key 0xF. The short timeout makes both expiry paths cheap to reach, so the busy period can be counted cycle by cycle against the exact limit: a request that is never accepted, and one that is accepted but never answered. The same build also lets the bench try locked-field writes during a stall long enough to hold several of them.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  localparam logic [7:0] OP_REG_RD = 8'h06;
  localparam logic [7:0] OP_CFG_RD = 8'h04;
  localparam logic [1:0] RSP_TIMEOUT  = 2'd2;
  localparam logic [1:0] RSP_BADROUTE = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} eng_state_e;

  function automatic logic op_is_read(input logic [7:0] op);
    return (op == OP_REG_RD) || (op == OP_CFG_RD);
  endfunction
endpackage

// File: rtl/sbb_regs.sv
module sbb_regs #(
  parameter int DW  = 32,
  parameter int HAW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [HAW-1:0]  host_addr,
  input  logic [DW/8-1:0] host_be,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic            done,
  input  logic [1:0]      done_resp,
  input  logic            done_load,
  input  logic [DW-1:0]   done_data,
  output logic [DW-1:0]   index_q,
  output logic [DW-1:0]   data_q,
  output logic [7:0]      opcode_q,
  output logic [15:0]     route_q,
  output logic            busy_q,
  output logic            start
);
  localparam int NB = DW / 8;
  localparam logic [HAW-1:0] A_INDEX = HAW'(0);
  localparam logic [HAW-1:0] A_DATA  = HAW'(4);
  localparam logic [HAW-1:0] A_CTRL  = HAW'(8);

  logic [1:0]    resp_q, resp_d;
  logic [DW-1:0] index_d, data_d, data_wr;
  logic [7:0]    opcode_d;
  logic [15:0]   route_d;
  logic          busy_d;
  logic          wr_idx, wr_dat, wr_ctl;

  // Host writes are accepted only while idle (R10)
  assign wr_idx = host_we && !busy_q && (host_addr == A_INDEX);
  assign wr_dat = host_we && !busy_q && (host_addr == A_DATA);
  assign wr_ctl = host_we && !busy_q && (host_addr == A_CTRL);
  assign start  = wr_ctl && host_be[0] && host_wdata[0];

  // Byte-lane merge for the two full-width registers (R2)
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign index_d[8*b +: 8] = (wr_idx && host_be[b]) ? host_wdata[8*b +: 8] : index_q[8*b +: 8];
    assign data_wr[8*b +: 8] = (wr_dat && host_be[b]) ? host_wdata[8*b +: 8] : data_q[8*b +: 8];
  end

  always_comb begin
    data_d        = (done && done_load) ? done_data : data_wr;
    opcode_d      = (wr_ctl && host_be[1]) ? host_wdata[15:8]  : opcode_q;
    route_d[7:0]  = (wr_ctl && host_be[2]) ? host_wdata[23:16] : route_q[7:0];
    route_d[15:8] = (wr_ctl && host_be[3]) ? host_wdata[31:24] : route_q[15:8];
    busy_d        = start || (busy_q && !done);
    resp_d        = done ? done_resp : resp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q  <= '0;
      data_q   <= '0;
      opcode_q <= '0;
      route_q  <= '0;
      busy_q   <= 1'b0;
      resp_q   <= '0;
    end else begin
      if (wr_idx) index_q <= index_d;
      if (wr_dat || done) data_q <= data_d;
      if (wr_ctl) begin
        opcode_q <= opcode_d;
        route_q  <= route_d;
      end
      busy_q <= busy_d;
      if (done) resp_q <= resp_d;
    end
  end

  always_comb begin
    case (host_addr)
      A_INDEX: host_rdata = index_q;
      A_DATA:  host_rdata = data_q;
      A_CTRL:  host_rdata = DW'({route_q, opcode_q, 5'b0, resp_q, busy_q});
      default: host_rdata = '0;
    endcase
  end

  // R7: completion code moves only with the falling busy bit
  p_resp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_q) |-> $stable(resp_q));

  // R10: locked fields survive host writes issued while busy
  p_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && host_we) |=> ($stable(index_q) && $stable(opcode_q) && $stable(route_q)));
endmodule

// File: rtl/sbb_timer.sv
module sbb_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d   = run ? cnt_q + 1'b1 : '0;
    expired = run && (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: an expiry always closes the transaction on the next edge
  p_expire_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !run);
endmodule

// File: rtl/sbb_engine.sv
module sbb_engine import sbb_pkg::*; #(
  parameter int         DW  = 32,
  parameter logic [3:0] KEY = 4'hF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] index_q,
  input  logic [DW-1:0] data_q,
  input  logic [7:0]    opcode_q,
  input  logic [3:0]    route_key,
  input  logic [7:0]    route_id,
  input  logic          expired,
  output logic          bk_req_valid,
  input  logic          bk_req_ready,
  output logic [DW-1:0] bk_req_addr,
  output logic [7:0]    bk_req_op,
  output logic [7:0]    bk_req_route,
  output logic [DW-1:0] bk_req_wdata,
  input  logic          bk_rsp_valid,
  input  logic [DW-1:0] bk_rsp_data,
  input  logic [1:0]    bk_rsp_status,
  output logic          run,
  output logic          done,
  output logic [1:0]    done_resp,
  output logic          done_load,
  output logic [DW-1:0] done_data
);
  eng_state_e state_q, state_d;
  logic       key_ok;

  assign key_ok       = (route_key == KEY);
  assign run          = (state_q != ST_IDLE);
  assign bk_req_valid = (state_q == ST_REQ) && key_ok && !expired;
  assign bk_req_addr  = index_q;
  assign bk_req_op    = opcode_q;
  assign bk_req_route = route_id;
  assign bk_req_wdata = data_q;
  assign done_data    = bk_rsp_data;

  always_comb begin
    state_d   = state_q;
    done      = 1'b0;
    done_resp = '0;
    done_load = 1'b0;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_REQ;
      ST_REQ: begin
        if (!key_ok) begin
          done      = 1'b1;
          done_resp = RSP_BADROUTE;
          state_d   = ST_IDLE;
        end else if (expired) begin
          done      = 1'b1;
          done_resp = RSP_TIMEOUT;
          state_d   = ST_IDLE;
        end else if (bk_req_ready) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (bk_rsp_valid) begin
          done      = 1'b1;
          done_resp = bk_rsp_status;
          done_load = op_is_read(opcode_q);
          state_d   = ST_IDLE;
        end else if (expired) begin
          done      = 1'b1;
          done_resp = RSP_TIMEOUT;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R8: nothing reaches the backend with a wrong routing key
  p_key_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bk_req_valid |-> (route_key == KEY));

  // R4: an offered request holds until accepted or timed out
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_req_valid && !bk_req_ready) |=>
      ((bk_req_valid || expired) && $stable(bk_req_addr) && $stable(bk_req_op)
       && $stable(bk_req_route) && $stable(bk_req_wdata)));
endmodule

// File: rtl/sideband_bridge.sv
module sideband_bridge #(
  parameter int         DW        = 32,
  parameter int         HAW       = 4,
  parameter int         TIMEOUT   = 1024,
  parameter logic [3:0] ROUTE_KEY = 4'hF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [HAW-1:0]  host_addr,
  input  logic [DW/8-1:0] host_be,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            bk_req_valid,
  input  logic            bk_req_ready,
  output logic [DW-1:0]   bk_req_addr,
  output logic [7:0]      bk_req_op,
  output logic [7:0]      bk_req_route,
  output logic [DW-1:0]   bk_req_wdata,
  input  logic            bk_rsp_valid,
  input  logic [DW-1:0]   bk_rsp_data,
  input  logic [1:0]      bk_rsp_status
);
  logic [1:0]    rst_pipe;
  logic          rst_n_s;
  logic [DW-1:0] index_q, data_q, done_data;
  logic [7:0]    opcode_q;
  logic [15:0]   route_q;
  logic          busy_q, start, done, done_load, run, expired;
  logic [1:0]    done_resp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  sbb_regs #(.DW(DW), .HAW(HAW)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .host_we(host_we), .host_addr(host_addr), .host_be(host_be),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .done(done), .done_resp(done_resp), .done_load(done_load), .done_data(done_data),
    .index_q(index_q), .data_q(data_q), .opcode_q(opcode_q), .route_q(route_q),
    .busy_q(busy_q), .start(start)
  );

  sbb_engine #(.DW(DW), .KEY(ROUTE_KEY)) u_engine (
    .clk(clk), .rst_n(rst_n_s), .start(start),
    .index_q(index_q), .data_q(data_q), .opcode_q(opcode_q),
    .route_key(route_q[15:12]), .route_id(route_q[7:0]), .expired(expired),
    .bk_req_valid(bk_req_valid), .bk_req_ready(bk_req_ready),
    .bk_req_addr(bk_req_addr), .bk_req_op(bk_req_op),
    .bk_req_route(bk_req_route), .bk_req_wdata(bk_req_wdata),
    .bk_rsp_valid(bk_rsp_valid), .bk_rsp_data(bk_rsp_data), .bk_rsp_status(bk_rsp_status),
    .run(run), .done(done), .done_resp(done_resp), .done_load(done_load), .done_data(done_data)
  );

  sbb_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .run(run), .expired(expired)
  );

  // R3: busy is raised only together with the engine leaving idle
  p_busy_tracks_run_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(busy_q) |-> run);
endmodule

// File: tb/sideband_bridge_tb.sv
module sideband_bridge_tb;
  localparam int DW = 32, HAW = 4, TMO = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic host_we;
  logic [HAW-1:0] host_addr;
  logic [3:0] host_be;
  logic [DW-1:0] host_wdata, host_rdata;
  logic bk_req_valid, bk_req_ready;
  logic [DW-1:0] bk_req_addr, bk_req_wdata;
  logic [7:0] bk_req_op, bk_req_route;
  logic bk_rsp_valid;
  logic [DW-1:0] bk_rsp_data;
  logic [1:0] bk_rsp_status;

  always #4 clk = ~clk;

  sideband_bridge #(.DW(DW), .HAW(HAW), .TIMEOUT(TMO), .ROUTE_KEY(4'hF)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bk_req_valid(bk_req_valid), .bk_req_ready(bk_req_ready),
    .bk_req_addr(bk_req_addr), .bk_req_op(bk_req_op), .bk_req_route(bk_req_route),
    .bk_req_wdata(bk_req_wdata), .bk_rsp_valid(bk_rsp_valid),
    .bk_rsp_data(bk_rsp_data), .bk_rsp_status(bk_rsp_status)
  );

  int n_chk = 0, n_fail = 0;
  logic [79:0] req_q[$];
  bit bk_respond = 1'b1;
  int bk_lat = 1;
  logic [31:0] bk_rd = '0;
  logic [1:0] bk_st = '0;

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [HAW-1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_be = be; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [HAW-1:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  // Backend model: answers an accepted request after bk_lat cycles
  initial begin
    bk_rsp_valid = 1'b0; bk_rsp_data = '0; bk_rsp_status = '0;
    forever begin
      @(negedge clk);
      if (bk_req_valid && bk_req_ready && bk_respond) begin
        repeat (bk_lat) @(negedge clk);
        bk_rsp_valid = 1'b1; bk_rsp_data = bk_rd; bk_rsp_status = bk_st;
        @(negedge clk);
        bk_rsp_valid = 1'b0;
      end
    end
  end

  // Monitor: every accepted request must match the next expected one (R3, R6, R8)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bk_req_valid && bk_req_ready) begin
        logic [79:0] got, e;
        got = {bk_req_addr, bk_req_op, bk_req_route, bk_req_wdata};
        if (req_q.size() == 0) chk(1'b0, "R3/R8 unexpected request", got, '0);
        else begin
          e = req_q.pop_front();
          chk(got == e, "R3 request fields", got, e);
        end
      end
    end
  end

  task automatic run_txn(input logic [31:0] idx, input logic [7:0] op, input logic [15:0] route,
                         input logic [31:0] wd, input bit rdy, input bit respond, input int lat,
                         input logic [31:0] rd, input logic [1:0] st, input logic [1:0] exp_resp,
                         input logic [31:0] exp_data, input int exp_busy, input string tag);
    logic [31:0] s, d;
    logic [1:0] prev;
    int cnt;
    bk_req_ready = rdy; bk_respond = respond; bk_lat = lat; bk_rd = rd; bk_st = st;
    hwrite(4'h0, 4'hF, idx);
    hwrite(4'h4, 4'hF, wd);
    hwrite(4'h8, 4'b1100, {route, 16'h0});
    if (route[15:12] == 4'hF && rdy) req_q.push_back({idx, op, route[7:0], wd});
    hread(4'h8, s);
    prev = s[2:1];
    hwrite(4'h8, 4'b0011, {16'h0, op, 8'h01});
    hread(4'h8, s);
    chk(s[0] == 1'b1, {tag, " R3 busy after go"}, s, 1);
    chk(s[2:1] == prev, {tag, " R7 code held while busy"}, s[2:1], prev);
    cnt = 0;
    while (s[0]) begin
      cnt++;
      if (!rdy && route[15:12] == 4'hF && (cnt == 2 || cnt == TMO - 2))
        chk(bk_req_valid && bk_req_addr == idx && bk_req_op == op && bk_req_wdata == wd,
            {tag, " R4 request held"}, {bk_req_valid, bk_req_addr}, {1'b1, idx});
      @(negedge clk);
      hread(4'h8, s);
    end
    if (exp_busy > 0) chk(cnt == exp_busy, {tag, " busy length"}, cnt, exp_busy);
    chk(s[2:1] == exp_resp, {tag, " completion code"}, s[2:1], exp_resp);
    hread(4'h4, d);
    chk(d == exp_data, {tag, " data register"}, d, exp_data);
    bk_req_ready = 1'b1; bk_respond = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    host_we = 1'b0; host_addr = '0; host_be = '0; host_wdata = '0; bk_req_ready = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    hread(4'h0, v); chk(v == 0, "R1 index reset", v, 0);
    hread(4'h4, v); chk(v == 0, "R1 data reset", v, 0);
    hread(4'h8, v); chk(v == 0, "R1 control reset", v, 0);

    run_txn(32'h0000_1234, 8'h07, 16'hF012, 32'hDEAD_BEEF, 1, 1, 1, 32'h1111_1111, 2'd0,
            2'd0, 32'hDEAD_BEEF, 2, "R6 reg write");
    run_txn(32'h0000_0040, 8'h06, 16'hF0A5, 32'h0, 1, 1, 3, 32'hCAFE_F00D, 2'd0,
            2'd0, 32'hCAFE_F00D, 4, "R5 reg read");
    run_txn(32'h0000_0088, 8'h04, 16'hF111, 32'h2222_2222, 1, 1, 2, 32'h0BAD_C0DE, 2'd1,
            2'd1, 32'h0BAD_C0DE, 3, "R5 cfg read fail");
    run_txn(32'h0000_0099, 8'h05, 16'hF3C4, 32'h1357_2468, 1, 1, 1, 32'hFFFF_FFFF, 2'd2,
            2'd2, 32'h1357_2468, 2, "R6 cfg write fail");
    run_txn(32'h0000_0777, 8'h06, 16'h7033, 32'h55AA_55AA, 1, 1, 1, 32'h0, 2'd0,
            2'd3, 32'h55AA_55AA, 1, "R8 bad key");

    // R2: byte-lane writes into the control and index words
    hwrite(4'h8, 4'b0010, {16'h0, 8'hAB, 8'hFF});
    hread(4'h8, v); chk(v == 32'h7033_AB06, "R2 opcode lane only, no go", v, 32'h7033_AB06);
    hwrite(4'h8, 4'b0100, 32'h005A_0000);
    hread(4'h8, v); chk(v == 32'h705A_AB06, "R2 route id lane", v, 32'h705A_AB06);
    hwrite(4'h0, 4'b0010, 32'h0000_9900);
    hread(4'h0, v); chk(v == 32'h0000_9977, "R2 index lane", v, 32'h0000_9977);

    run_txn(32'h0000_0100, 8'h07, 16'hF001, 32'hA5A5_0001, 0, 0, 1, 32'h0, 2'd0,
            2'd2, 32'hA5A5_0001, TMO, "R9 timeout unaccepted");
    run_txn(32'h0000_0200, 8'h06, 16'hF002, 32'hA5A5_0002, 1, 0, 1, 32'h0, 2'd0,
            2'd2, 32'hA5A5_0002, TMO, "R9 timeout no response");

    // R10: writes during a stalled transaction leave all fields untouched
    bk_req_ready = 1'b0; bk_respond = 1'b0;
    hwrite(4'h0, 4'hF, 32'hA0A0_A0A0);
    hwrite(4'h4, 4'hF, 32'h0F0F_0F0F);
    hwrite(4'h8, 4'b1100, 32'hF0C3_0000);
    hwrite(4'h8, 4'b0011, 32'h0000_0701);
    hwrite(4'h0, 4'hF, 32'h1234_5678);
    hwrite(4'h4, 4'hF, 32'h9ABC_DEF0);
    hwrite(4'h8, 4'hF, 32'hF0FF_0601);
    hread(4'h8, v);
    while (v[0]) begin
      @(negedge clk);
      hread(4'h8, v);
    end
    chk(v == 32'hF0C3_0704, "R10 control word kept", v, 32'hF0C3_0704);
    hread(4'h0, v); chk(v == 32'hA0A0_A0A0, "R10 index kept", v, 32'hA0A0_A0A0);
    hread(4'h4, v); chk(v == 32'h0F0F_0F0F, "R10 data kept", v, 32'h0F0F_0F0F);
    bk_req_ready = 1'b1; bk_respond = 1'b1;
    repeat (4) @(negedge clk);

    chk(req_q.size() == 0, "R3 all expected requests seen", req_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule